// File: doc/BRIEF.md
# Redundant Load Value Queue

This block lets a pair of redundant load instructions read memory only once. The first copy of a load (the primary) is sent to memory. The block gives it a queue slot, and that slot records the load address. When memory returns the data, the data is written into the slot named by the response tag. The second copy (the duplicate) computes its address from its own shadow registers. It never reaches memory: it is served from the oldest slot, so both copies see the same value while memory traffic stays at one access per load.

Slots are handed out in program order by primaries and drained in the same order by duplicates, so a load and its twin always meet in one slot. A duplicate whose address differs from the recorded address raises a fault flag. It still receives the recorded value. Primaries stall while every slot is occupied. A duplicate stalls until its slot holds data. Memory may answer primaries in any order, because each response carries the slot tag.

Top module: `dup_load_queue`

## Requirements
- R1: After reset the queue is empty: `pri_req_ready` is 1, and `dup_req_ready`, `dup_rsp_valid` and `dup_fault` are 0.
- R2: An accepted primary drives `mem_req_valid` in the same cycle, with its address on `mem_req_addr`. The slot tag on `mem_req_tag` counts 0, 1, …, DEPTH-1 and then wraps to 0, one step per accepted primary.
- R3: While DEPTH slots are occupied, `pri_req_ready` is 0 and a pending primary produces no `mem_req_valid`.
- R4: A memory response is written into the slot named by `mem_rsp_tag` only if that slot is occupied. A response to a free slot is dropped, and a later primary given that slot still waits for its own response.
- R5: `dup_req_ready` is 1 only when the oldest occupied slot holds its memory data. A duplicate presented earlier gets no response until then.
- R6: A duplicate is accepted in the cycle where `dup_req_valid` and `dup_req_ready` are both 1. `dup_rsp_valid` is 1 for exactly the next cycle and carries that slot's data. A duplicate never causes `mem_req_valid`.
- R7: If the duplicate's address differs from the address recorded in its slot, `dup_fault` is 1 in the response cycle and the recorded data is still returned. Matching addresses give `dup_fault` = 0.
- R8: Duplicates are served in primary allocation order, whatever order the memory responses arrive in.
- R9: The slot is freed at the edge where its duplicate is accepted. If the queue was full, `pri_req_ready` is 1 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_req_valid | input | 1 | Primary load presented |
| pri_req_addr | input | AW | Primary load address |
| pri_req_ready | output | 1 | A slot is free, so the primary is accepted |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_addr | output | AW | Read address |
| mem_req_tag | output | IW | Slot tag for the request |
| mem_rsp_valid | input | 1 | Memory read data returned |
| mem_rsp_tag | input | IW | Slot the data belongs to |
| mem_rsp_data | input | DW | Read data |
| dup_req_valid | input | 1 | Duplicate load presented |
| dup_req_addr | input | AW | Duplicate (shadow) address |
| dup_req_ready | output | 1 | Oldest slot has data, so the duplicate is accepted |
| dup_rsp_valid | output | 1 | Duplicate response valid |
| dup_rsp_data | output | DW | Value recorded by the primary |
| dup_fault | output | 1 | Address mismatch on this response |

## Verification
The following are checked on every cycle by the in-line properties:
- a full queue never issues a memory request;
- every accepted duplicate is followed by exactly one response;
- the fault flag appears only alongside a response;
- the occupancy count drops by one when a duplicate is served with no primary in the same cycle;
- a response to a free slot leaves that slot without data.

Other behaviour needs the directed scenarios:
- the tag sequence and its wrap;
- the data values returned;
- the ordering under responses arriving in reverse;
- the stall of an early duplicate;
- ready returning the cycle after a full queue is drained by one.

// File: rtl/lvq_pkg.sv
package lvq_pkg;

    typedef struct packed {
        logic        busy;
        logic        has_data;
    } slot_flags_t;

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/lvq_ptr.sv
module lvq_ptr #(
    parameter int DEPTH = 4,
    localparam int IW  = lvq_pkg::idx_width(DEPTH),
    localparam int CW  = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          release_slot,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full
);

    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [CW-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (alloc) begin
            st_d.tail = step(st_q.tail);
        end
        if (release_slot) begin
            st_d.head = step(st_q.head);
        end
        case ({alloc, release_slot})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign count = st_q.count;
    assign full  = (st_q.count == CW'(DEPTH));

    // R9
    free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (release_slot && !alloc) |=> (count == $past(count) - 1'b1));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !release_slot) |=> (count <= CW'(DEPTH)));

endmodule

// File: rtl/lvq_slots.sv
module lvq_slots #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = lvq_pkg::idx_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [IW-1:0] alloc_idx,
    input  logic [AW-1:0] alloc_addr,
    input  logic          wr_valid,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          release_slot,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_busy,
    output logic          rd_has_data,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    import lvq_pkg::*;

    typedef struct packed {
        slot_flags_t   flags;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } slot_t;

    slot_t slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t s_d, s_q;
        logic  hit_alloc, hit_wr, hit_rel;

        assign hit_alloc = alloc && (alloc_idx == IW'(g));
        assign hit_wr    = wr_valid && (wr_idx == IW'(g)) && s_q.flags.busy;
        assign hit_rel   = release_slot && (rd_idx == IW'(g));

        always_comb begin
            s_d = s_q;
            if (hit_wr) begin
                s_d.flags.has_data = 1'b1;
                s_d.data           = wr_data;
            end
            if (hit_rel) begin
                s_d.flags = '0;
            end
            if (hit_alloc) begin
                s_d.flags.busy     = 1'b1;
                s_d.flags.has_data = 1'b0;
                s_d.addr           = alloc_addr;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q <= '0;
            end else begin
                s_q <= s_d;
            end
        end

        assign slot_q[g] = s_q;

        // R4
        stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && wr_idx == IW'(g) && !s_q.flags.busy) |=> !s_q.flags.has_data);
    end

    always_comb begin
        rd_busy     = 1'b0;
        rd_has_data = 1'b0;
        rd_addr     = '0;
        rd_data     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IW'(i)) begin
                rd_busy     = slot_q[i].flags.busy;
                rd_has_data = slot_q[i].flags.has_data;
                rd_addr     = slot_q[i].addr;
                rd_data     = slot_q[i].data;
            end
        end
    end

endmodule

// File: rtl/dup_load_queue.sv
module dup_load_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = lvq_pkg::idx_width(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pri_req_valid,
    input  logic [AW-1:0] pri_req_addr,
    output logic          pri_req_ready,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic [IW-1:0] mem_req_tag,
    input  logic          mem_rsp_valid,
    input  logic [IW-1:0] mem_rsp_tag,
    input  logic [DW-1:0] mem_rsp_data,
    input  logic          dup_req_valid,
    input  logic [AW-1:0] dup_req_addr,
    output logic          dup_req_ready,
    output logic          dup_rsp_valid,
    output logic [DW-1:0] dup_rsp_data,
    output logic          dup_fault
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          fault;
    } rsp_t;

    logic [IW-1:0] head, tail;
    logic [CW-1:0] count;
    logic          full;
    logic          pri_fire, dup_fire;
    logic          h_busy, h_has_data;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_data;
    rsp_t          rsp_d, rsp_q;

    assign pri_req_ready = !full;
    assign pri_fire      = pri_req_valid && pri_req_ready;
    assign dup_req_ready = h_busy && h_has_data;
    assign dup_fire      = dup_req_valid && dup_req_ready;

    lvq_ptr #(.DEPTH(DEPTH)) ptr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc        (pri_fire),
        .release_slot (dup_fire),
        .head         (head),
        .tail         (tail),
        .count        (count),
        .full         (full)
    );

    lvq_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) slots_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc        (pri_fire),
        .alloc_idx    (tail),
        .alloc_addr   (pri_req_addr),
        .wr_valid     (mem_rsp_valid),
        .wr_idx       (mem_rsp_tag),
        .wr_data      (mem_rsp_data),
        .release_slot (dup_fire),
        .rd_idx       (head),
        .rd_busy      (h_busy),
        .rd_has_data  (h_has_data),
        .rd_addr      (h_addr),
        .rd_data      (h_data)
    );

    assign mem_req_valid = pri_fire;
    assign mem_req_addr  = pri_req_addr;
    assign mem_req_tag   = tail;

    always_comb begin
        rsp_d       = '0;
        rsp_d.data  = rsp_q.data;
        if (dup_fire) begin
            rsp_d.valid = 1'b1;
            rsp_d.data  = h_data;
            rsp_d.fault = (dup_req_addr != h_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign dup_rsp_valid = rsp_q.valid;
    assign dup_rsp_data  = rsp_q.data;
    assign dup_fault     = rsp_q.fault;

    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) |-> !mem_req_valid);

    // R6
    dup_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_req_valid && dup_req_ready) |=> dup_rsp_valid);

    // R6
    one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dup_req_valid && dup_req_ready) |=> !dup_rsp_valid);

    // R7
    fault_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_fault |-> dup_rsp_valid);

    // R5
    early_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !dup_req_ready);

endmodule

// File: tb/dup_load_queue_tb_top.sv
module dup_load_queue_tb_top;
    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int IW    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pri_req_valid = 1'b0;
    logic [AW-1:0] pri_req_addr = '0;
    logic          pri_req_ready;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic [IW-1:0] mem_req_tag;
    logic          mem_rsp_valid = 1'b0;
    logic [IW-1:0] mem_rsp_tag = '0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          dup_req_valid = 1'b0;
    logic [AW-1:0] dup_req_addr = '0;
    logic          dup_req_ready;
    logic          dup_rsp_valid;
    logic [DW-1:0] dup_rsp_data;
    logic          dup_fault;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_tail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dup_load_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pri_req_valid(pri_req_valid), .pri_req_addr(pri_req_addr), .pri_req_ready(pri_req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data),
        .dup_req_valid(dup_req_valid), .dup_req_addr(dup_req_addr), .dup_req_ready(dup_req_ready),
        .dup_rsp_valid(dup_rsp_valid), .dup_rsp_data(dup_rsp_data), .dup_fault(dup_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Primary that must be accepted; checks the memory request (R2).
    task automatic do_primary(input logic [AW-1:0] a);
        @(negedge clk);
        pri_req_valid = 1'b1;
        pri_req_addr  = a;
        #1;
        chk("R2 ready", pri_req_ready, 1);
        chk("R2 mem_req_valid", mem_req_valid, 1);
        chk("R2 mem_req_addr", mem_req_addr, a);
        chk("R2 tag", mem_req_tag, exp_tail);
        @(posedge clk);
        #1;
        pri_req_valid = 1'b0;
        exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic do_resp(input int tag, input logic [DW-1:0] d);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_tag   = IW'(tag);
        mem_rsp_data  = d;
        @(posedge clk);
        #1;
        mem_rsp_valid = 1'b0;
    endtask

    // Duplicate that must be accepted at once; checks response (R6, R7).
    task automatic do_dup(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                          input bit exp_f, input string req);
        @(negedge clk);
        dup_req_valid = 1'b1;
        dup_req_addr  = a;
        #1;
        chk({req, " dup ready"}, dup_req_ready, 1);
        chk("R6 no mem traffic from dup", mem_req_valid, 0);
        @(posedge clk);
        #1;
        dup_req_valid = 1'b0;
        chk("R6 rsp valid", dup_rsp_valid, 1);
        chk({req, " rsp data"}, dup_rsp_data, exp_d);
        chk("R7 fault", dup_fault, exp_f);
        @(posedge clk);
        #1;
        chk("R6 rsp single cycle", dup_rsp_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pri ready", pri_req_ready, 1);
        chk("R1 dup ready", dup_req_ready, 0);
        chk("R1 rsp valid", dup_rsp_valid, 0);
        chk("R1 fault", dup_fault, 0);
        exp_tail = 0;
    endtask

    task automatic t_basic();
        do_primary(32'h0000_1000);
        @(negedge clk);
        chk("R5 no data yet", dup_req_ready, 0);
        do_resp(0, 32'hCAFE_0001);
        do_dup(32'h0000_1000, 32'hCAFE_0001, 1'b0, "R6");
    endtask

    task automatic t_mismatch();
        do_primary(32'h0000_2000);
        do_resp(1, 32'hBEEF_0002);
        do_dup(32'h0000_2004, 32'hBEEF_0002, 1'b1, "R7");
    endtask

    task automatic t_full_order();
        logic [DW-1:0] dat [DEPTH];
        int tags [DEPTH];
        for (int i = 0; i < DEPTH; i++) begin
            tags[i] = exp_tail;
            dat[i]  = 32'hD000_0000 + i;
            do_primary(32'h0000_3000 + 32'(i * 4));
        end
        @(negedge clk);
        pri_req_valid = 1'b1;
        pri_req_addr  = 32'h0000_9999;
        #1;
        chk("R3 ready low when full", pri_req_ready, 0);
        chk("R3 no mem req when full", mem_req_valid, 0);
        @(posedge clk);
        #1;
        pri_req_valid = 1'b0;
        for (int i = DEPTH - 1; i >= 1; i--) begin
            do_resp(tags[i], dat[i]);
            @(negedge clk);
            chk("R8 oldest still waiting", dup_req_ready, 0);
        end
        do_resp(tags[0], dat[0]);
        do_dup(32'h0000_3000, dat[0], 1'b0, "R8");
        @(negedge clk);
        chk("R9 ready after free", pri_req_ready, 1);
        for (int i = 1; i < DEPTH; i++) begin
            do_dup(32'h0000_3000 + 32'(i * 4), dat[i], 1'b0, "R8");
        end
    endtask

    task automatic t_stray_rsp();
        int t;
        t = exp_tail;
        do_resp(t, 32'h5555_AAAA);
        do_primary(32'h0000_4000);
        @(negedge clk);
        chk("R4 stray rsp dropped", dup_req_ready, 0);
        do_resp(t, 32'h1234_5678);
        do_dup(32'h0000_4000, 32'h1234_5678, 1'b0, "R4");
    endtask

    task automatic t_early_dup();
        int t;
        t = exp_tail;
        do_primary(32'h0000_5000);
        @(negedge clk);
        dup_req_valid = 1'b1;
        dup_req_addr  = 32'h0000_5000;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            chk("R5 early dup held", dup_rsp_valid, 0);
            chk("R5 not ready", dup_req_ready, 0);
        end
        dup_req_valid = 1'b0;
        do_resp(t, 32'h7777_0005);
        do_dup(32'h0000_5000, 32'h7777_0005, 1'b0, "R5");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mismatch();
        t_full_order();
        t_stray_rsp();
        t_early_dup();
        t_full_order();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule